// File: doc/BRIEF.md
# Parallel Scrambler and NRZI Encoder

This block takes one 20-bit word per accepted transfer and, when scrambling is active, passes it through a self-synchronizing scrambler and then an NRZI encoder. Both are unrolled across the whole word, so the output is the same as a bit-serial circuit would produce if it were clocked twenty times with bit 0 first. The scrambler adds the scrambled bits from four and nine positions earlier to each data bit. The NRZI stage adds the previous encoded bit to each scrambled bit. Nine scrambled bits and one encoded bit are stored between words, so the serial sequence runs on without a break at word edges.

Scrambling is active only when the serializer-mode pin and the scramble-enable pin are both high. In every other case the word is copied to the output unchanged and the stored state stays as it is. Data enters and leaves through valid/ready streams and is registered once. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so back-pressure on `out_ready` stops the input within that cycle.

Top module: `scr_nrzi_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low. The scrambler history and the last NRZI bit reset to zero, so the first active word is coded from an all-zero state.
- R2: For an active word, bit i is handled in the serial order 0 to 19. The scrambled bit is s = d XOR s(4 bits earlier) XOR s(9 bits earlier), and the output bit is n = s XOR n(previous bit).
- R3: Scrambler history and NRZI state carry over from one active word to the next, so a sequence of words matches one continuous bit-serial stream.
- R4: With `scr_en` low, an accepted word appears on `out_data` unchanged.
- R5: With `ser_mode` low, an accepted word appears on `out_data` unchanged, whatever `scr_en` is.
- R6: Bypassed words and cycles with no transfer leave the scrambler and NRZI state unchanged. The next active word is coded as if they had not happened.
- R7: A word accepted at a clock edge shows up on `out_data`, with `out_valid` high, right after that edge (one clock of latency).
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and `in_ready` is low. `in_ready` equals (NOT `out_valid`) OR `out_ready`.
- R9: A matching descrambler starting from any state recovers the original data exactly once it has taken in 10 encoded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | High selects serializer mode |
| scr_en | input | 1 | High enables scrambling (only used in serializer mode) |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 20 | Input word, bit 0 first in time |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 20 | Coded or bypassed word, bit 0 first in time |

## Verification
Every result is due one clock after the edge that accepts the word. The bench drives inputs on the falling edge and reads `out_data` and `out_valid` on the next falling edge, half a cycle after the result registers. `in_ready` is combinational, so it is checked in the same half cycle as the `out_ready` change that causes it. During back-pressure, the output is sampled again on each stalled cycle, and the bench updates its serial reference model only for the edge that actually accepts a word. Descrambler recovery is judged from the second word onward, because 20 bits is more than the 10 bits needed to synchronize.

// File: rtl/scr_nrzi_pkg.sv
package scr_nrzi_pkg;
  parameter int WORD_W   = 20;
  parameter int TAP_NEAR = 4;
  parameter int TAP_FAR  = 9;
endpackage

// File: rtl/scr_scramble_stage.sv
module scr_scramble_stage #(
  parameter int W    = scr_nrzi_pkg::WORD_W,
  parameter int NEAR = scr_nrzi_pkg::TAP_NEAR,
  parameter int FAR  = scr_nrzi_pkg::TAP_FAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o
);
  localparam int EXT_W = W + FAR;

  // hist_q[0] is the oldest stored bit, hist_q[FAR-1] the newest
  logic [FAR-1:0]   hist_q;
  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = '0;
    ext[FAR-1:0] = hist_q;
    for (int i = 0; i < W; i++) begin
      ext[FAR+i] = d_i[i] ^ ext[FAR+i-NEAR] ^ ext[i];
    end
  end

  assign s_o = ext[EXT_W-1:FAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (advance) hist_q <= ext[EXT_W-1:W];
  end

  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(hist_q));
endmodule

// File: rtl/scr_nrzi_stage.sv
module scr_nrzi_stage #(
  parameter int W = scr_nrzi_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] n_o,
  output logic         last_o
);
  logic last_q;

  always_comb begin
    logic run;
    run = last_q;
    n_o = '0;
    for (int i = 0; i < W; i++) begin
      run    = run ^ s_i[i];
      n_o[i] = run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b0;
    else if (advance) last_q <= n_o[W-1];
  end

  assign last_o = last_q;

  assert_last_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(last_q));
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int W = scr_nrzi_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_i,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= word_i;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_load_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
endmodule

// File: rtl/scr_nrzi_top.sv
module scr_nrzi_top #(
  parameter int W    = scr_nrzi_pkg::WORD_W,
  parameter int NEAR = scr_nrzi_pkg::TAP_NEAR,
  parameter int FAR  = scr_nrzi_pkg::TAP_FAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_mode,
  input  logic         scr_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         accept;
  logic         active;
  logic         advance;
  logic [W-1:0] scr_word;
  logic [W-1:0] nrzi_word;
  logic [W-1:0] next_word;
  logic         nrzi_last;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign active    = ser_mode && scr_en;
  assign advance   = accept && active;
  assign next_word = active ? nrzi_word : in_data;

  scr_scramble_stage #(.W(W), .NEAR(NEAR), .FAR(FAR)) u_scr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .d_i(in_data), .s_o(scr_word)
  );

  scr_nrzi_stage #(.W(W)) u_nrzi (
    .clk(clk), .rst_n(rst_n), .advance(advance), .s_i(scr_word),
    .n_o(nrzi_word), .last_o(nrzi_last)
  );

  scr_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .word_i(next_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  // R4 and R5: a bypassed word leaves the block untouched
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !active |=> out_data == $past(in_data));
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_nrzi_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> out_data[W-1] == nrzi_last);
endmodule

// File: tb/scr_nrzi_top_test.sv
module scr_nrzi_top_test;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_mode = 1'b0;
  logic         scr_en = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench reference state: m_hist[0] is one bit ago, m_hist[8] nine bits ago
  logic [8:0] m_hist = '0;
  logic       m_n = 1'b0;
  logic [8:0] u_hist = '1;
  logic       u_n = 1'b1;

  scr_nrzi_top uut (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .scr_en(scr_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_word(input logic [W-1:0] d, output logic [W-1:0] o);
    for (int i = 0; i < W; i++) begin
      logic s;
      s = d[i] ^ m_hist[3] ^ m_hist[8];
      m_hist = {m_hist[7:0], s};
      m_n = m_n ^ s;
      o[i] = m_n;
    end
  endtask

  task automatic descramble_word(input logic [W-1:0] n, output logic [W-1:0] d);
    for (int i = 0; i < W; i++) begin
      logic s;
      s = n[i] ^ u_n;
      u_n = n[i];
      d[i] = s ^ u_hist[3] ^ u_hist[8];
      u_hist = {u_hist[7:0], s};
    end
  endtask

  // drive one word, let it be accepted, check it one clock later
  task automatic send_word(input string req, input logic [W-1:0] d, input logic en,
                           input logic mode, output logic [W-1:0] got);
    logic [W-1:0] exp;
    @(negedge clk);
    scr_en = en; ser_mode = mode; in_data = d; in_valid = 1'b1; out_ready = 1'b1;
    if (en && mode) model_word(d, exp);
    else exp = d;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " latency R7 valid"}, {19'd0, out_valid}, 20'd1);
    check(req, out_data, exp);
    got = out_data;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {19'd0, out_valid}, 20'd0);
    check("R8 ready in reset", {19'd0, in_ready}, 20'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {19'd0, out_valid}, 20'd0);
  endtask

  task automatic test_patterns();
    logic [W-1:0] g;
    send_word("R1 first word zero state", 20'h00000, 1'b1, 1'b1, g);
    send_word("R2 single bit0", 20'h00001, 1'b1, 1'b1, g);
    send_word("R2 all ones", 20'hFFFFF, 1'b1, 1'b1, g);
    send_word("R2 alternating", 20'hAAAAA, 1'b1, 1'b1, g);
    send_word("R2 top bit", 20'h80000, 1'b1, 1'b1, g);
  endtask

  task automatic test_continuity();
    logic [W-1:0] g;
    for (int k = 0; k < 8; k++) send_word("R3 stream", W'($urandom), 1'b1, 1'b1, g);
  endtask

  task automatic test_bypass();
    logic [W-1:0] g;
    send_word("R4 scr_en low", 20'h5A5A5, 1'b0, 1'b1, g);
    send_word("R5 ser_mode low", 20'hC3C3C, 1'b1, 1'b0, g);
    send_word("R5 both low", 20'h0F0F0, 1'b0, 1'b0, g);
    send_word("R6 after bypass", 20'h12345, 1'b1, 1'b1, g);
    repeat (5) @(negedge clk);
    check("R6 idle no valid", {19'd0, out_valid}, 20'd0);
    send_word("R6 after idle", 20'h6789A, 1'b1, 1'b1, g);
  endtask

  task automatic test_backpressure();
    logic [W-1:0] ea, eb;
    @(negedge clk);
    scr_en = 1'b1; ser_mode = 1'b1; out_ready = 1'b0;
    in_data = 20'hABCDE; in_valid = 1'b1;
    model_word(20'hABCDE, ea);
    @(negedge clk);
    check("R7 stalled word valid", {19'd0, out_valid}, 20'd1);
    check("R8 first word", out_data, ea);
    check("R8 ready low", {19'd0, in_ready}, 20'd0);
    in_data = 20'h13579;
    repeat (3) @(negedge clk);
    check("R8 held data", out_data, ea);
    check("R8 still stalled", {19'd0, in_ready}, 20'd0);
    out_ready = 1'b1;
    #1;
    check("R8 ready follows out_ready", {19'd0, in_ready}, 20'd1);
    model_word(20'h13579, eb);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second word", out_data, eb);
    check("R8 second valid", {19'd0, out_valid}, 20'd1);
  endtask

  task automatic test_descramble();
    logic [W-1:0] g, src, rec;
    int bad = 0;
    for (int k = 0; k < 6; k++) begin
      src = W'($urandom);
      send_word("R9 coded", src, 1'b1, 1'b1, g);
      descramble_word(g, rec);
      if (k > 0) check("R9 recovered", rec, src);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    test_reset();
    test_patterns();
    test_continuity();
    test_bypass();
    test_backpressure();
    test_descramble();
    report();
  end
endmodule